// File: doc/BRIEF.md
# Capture-Compare Timer

This block is a 16-bit general-purpose timer for a peripheral subsystem. A count clock is chosen from one of four sources: stopped, the system clock, the system clock divided by sixteen, or rising edges of an external input. That count clock then passes through an 8-bit prescaler. The resulting ticks advance a counter. The counter is compared against a reference value. When the two match, a flag is raised, the timer output pin either pulses low or toggles, and the counter either runs on or wraps back to zero.

A separate capture input is synchronised and edge-detected. On the edge it selects, it copies the running counter into a capture register and raises a second flag. Both flags are held in an event register that software clears by writing ones. Each flag has its own enable bit, and together they drive a level interrupt request.

Software reaches the unit through a plain register port. The port has a strobe, a write flag, a 3-bit address and 16-bit data. Writes take effect on the clock edge. Read data follows the address combinationally and has no side effects. No part of the block streams data, so there is no valid/ready handshake and no back-pressure.

Top module: `gpt_timer`

## Requirements
- R1: After reset the mode register reads 0 (count source stopped), capture reads 0, counter reads 0, reference reads 0xFFFF, the event register reads 0, `tmr_out` is 1 and `irq` is 0.
- R2: Register addresses are 0 mode, 1 capture (read only), 2 counter, 3 reference, 4 event. Mode bits are [1:0] count source, [2] restart enable, [3] reference interrupt enable, [4] toggle output mode, [5] capture interrupt enable, [7:6] capture edge, [15:8] prescale. In the event register, bit 0 is the capture flag and bit 1 is the reference flag.
- R3: Count source code 0 stops counting. Code 1 offers a count clock every system clock. Code 2 offers one every 16 system clocks, starting 16 clocks after a mode write. Code 3 offers one per rising edge of `ext_clk_in`, seen after a two-flop synchroniser.
- R4: The prescaler passes one tick per (prescale+1) offered count clocks. Writing the mode register restarts the prescaler and the divide-by-16 phase, so with source 1 and prescale p the first tick lands on the (p+1)-th clock edge after the write.
- R5: With restart enabled, a tick that finds the counter equal to the reference loads 0. The counter therefore runs 0..reference.
- R6: With restart disabled, the counter runs freely and wraps from 0xFFFF to 0.
- R7: Any write to the counter address clears the counter to 0, taking priority over a tick in the same cycle.
- R8: A reference match is the clock edge at which a tick moves the counter onto the reference value. It sets the reference flag. In pulse mode (mode bit 4 = 0), it drives `tmr_out` low for exactly the following cycle.
- R9: In toggle mode (mode bit 4 = 1), `tmr_out` inverts at every reference match and holds otherwise.
- R10: Capture edge code 0 disables capture, 1 selects rising, 2 selects falling and 3 selects either. An edge on `cap_in` that is applied between clock edges k and k+1 stores, at edge k+3, the counter value present after edge k+2, and sets the capture flag.
- R11: Writing 1 to an event bit clears it and writing 0 leaves it. If a set from hardware and a clear land in the same cycle, the set wins.
- R12: `irq` is high while (capture flag AND capture enable) OR (reference flag AND reference enable).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when set together with `bus_sel` |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| ext_clk_in | input | 1 | External count source, asynchronous |
| cap_in | input | 1 | Capture trigger, asynchronous |
| tmr_out | output | 1 | Compare output pin |
| irq | output | 1 | Interrupt request, active high |

## Verification
Two events can fall in the same cycle: a capture edge and a reference match, which both update the event register on one edge. The bench provokes this by raising `cap_in` three clock edges before the edge on which a restarting counter reaches its reference. It then checks that both flags rise together, and that the stored capture value is the count one below the reference. In the same run, a write-one-to-clear is timed onto the next reference match, and the bench checks that the freshly set reference flag survives while the capture flag is cleared.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam int GPT_W     = 16;
  localparam int GPT_PSC_W = 8;
  localparam int GPT_AW    = 3;

  localparam logic [GPT_AW-1:0] A_MODE = 3'd0;
  localparam logic [GPT_AW-1:0] A_CAPT = 3'd1;
  localparam logic [GPT_AW-1:0] A_CNT  = 3'd2;
  localparam logic [GPT_AW-1:0] A_REFV = 3'd3;
  localparam logic [GPT_AW-1:0] A_EVT  = 3'd4;

  localparam logic [1:0] SRC_STOP  = 2'd0;
  localparam logic [1:0] SRC_SYS   = 2'd1;
  localparam logic [1:0] SRC_DIV16 = 2'd2;
  localparam logic [1:0] SRC_EXT   = 2'd3;

  localparam logic [1:0] EDGE_OFF  = 2'd0;
  localparam logic [1:0] EDGE_RISE = 2'd1;
  localparam logic [1:0] EDGE_FALL = 2'd2;
  localparam logic [1:0] EDGE_ANY  = 2'd3;

  typedef struct packed {
    logic [GPT_PSC_W-1:0] psc;
    logic [1:0]           cap_edge;
    logic                 cap_ie;
    logic                 out_toggle;
    logic                 ref_ie;
    logic                 restart;
    logic [1:0]           clk_src;
  } mode_t;
endpackage

// File: rtl/gpt_sync.sv
module gpt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic lvl,
  output logic lvl_d
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      lvl_d <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], d};
      lvl_d <= chain[STAGES-1];
    end
  end

  assign lvl = chain[STAGES-1];
endmodule

// File: rtl/gpt_tick_gen.sv
module gpt_tick_gen import gpt_pkg::*; #(
  parameter int PSC_W = GPT_PSC_W,
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_psc,
  input  logic [1:0]       src,
  input  logic [PSC_W-1:0] psc,
  input  logic             ext_rise,
  output logic             tick
);
  localparam logic [DIV_W-1:0] DIV_LAST = {DIV_W{1'b1}};

  logic [DIV_W-1:0] div_cnt;
  logic [PSC_W-1:0] ps_cnt;
  logic             base;

  always_comb begin
    unique case (src)
      SRC_SYS:   base = 1'b1;
      SRC_DIV16: base = (div_cnt == DIV_LAST);
      SRC_EXT:   base = ext_rise;
      default:   base = 1'b0;
    endcase
  end

  assign tick = base && (ps_cnt == psc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      ps_cnt  <= '0;
    end else if (restart_psc) begin
      div_cnt <= '0;
      ps_cnt  <= '0;
    end else begin
      div_cnt <= div_cnt + 1'b1;
      if (base) ps_cnt <= (ps_cnt == psc) ? '0 : ps_cnt + 1'b1;
    end
  end

  // R4: the prescaler phase never runs past the programmed divisor
  a_r4_psc_range: assert property (@(posedge clk) disable iff (!rst_n)
    ps_cnt <= psc);
endmodule

// File: rtl/gpt_capture.sv
module gpt_capture import gpt_pkg::*; #(
  parameter int W      = GPT_W,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_in,
  input  logic [1:0]   edge_sel,
  input  logic [W-1:0] cnt,
  output logic         cap_evt,
  output logic [W-1:0] cap_val
);
  logic s_lvl, s_prev, rise, fall;

  gpt_sync #(.STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(cap_in), .lvl(s_lvl), .lvl_d(s_prev)
  );

  assign rise = s_lvl & ~s_prev;
  assign fall = ~s_lvl & s_prev;

  always_comb begin
    unique case (edge_sel)
      EDGE_RISE: cap_evt = rise;
      EDGE_FALL: cap_evt = fall;
      EDGE_ANY:  cap_evt = rise | fall;
      default:   cap_evt = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cap_val <= '0;
    else if (cap_evt) cap_val <= cnt;
  end

  // R10: a qualifying edge stores the counter seen in that cycle
  a_r10_cap_value: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (cap_val == $past(cnt)));
  // R10: with capture disabled the stored value is untouched
  a_r10_cap_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_sel == EDGE_OFF) |=> $stable(cap_val));
endmodule

// File: rtl/gpt_timer.sv
module gpt_timer import gpt_pkg::*; #(
  parameter int CNT_W       = GPT_W,
  parameter int DIV_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [GPT_AW-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic              ext_clk_in,
  input  logic              cap_in,
  output logic              tmr_out,
  output logic              irq
);
  localparam logic [CNT_W-1:0] REF_RST = {CNT_W{1'b1}};

  mode_t            mode_q;
  logic [CNT_W-1:0] ref_q, cnt_q, cnt_inc, cap_val;
  logic             cap_flag, ref_flag;
  logic             wr_any, wr_mode, wr_cnt, wr_ref, wr_evt;
  logic             ext_lvl, ext_prev, ext_rise;
  logic             tick, cap_evt, ref_hit, wrap_now;

  // register port decode
  assign wr_any  = bus_sel & bus_wr;
  assign wr_mode = wr_any && (bus_addr == A_MODE);
  assign wr_cnt  = wr_any && (bus_addr == A_CNT);
  assign wr_ref  = wr_any && (bus_addr == A_REFV);
  assign wr_evt  = wr_any && (bus_addr == A_EVT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ref_q  <= REF_RST;
    end else begin
      if (wr_mode) mode_q <= mode_t'(bus_wdata);
      if (wr_ref)  ref_q  <= bus_wdata;
    end
  end

  always_comb begin
    unique case (bus_addr)
      A_MODE:  bus_rdata = CNT_W'(mode_q);
      A_CAPT:  bus_rdata = cap_val;
      A_CNT:   bus_rdata = cnt_q;
      A_REFV:  bus_rdata = ref_q;
      A_EVT:   bus_rdata = {{(CNT_W-2){1'b0}}, ref_flag, cap_flag};
      default: bus_rdata = '0;
    endcase
  end

  // count clock path
  gpt_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_clk_in), .lvl(ext_lvl), .lvl_d(ext_prev)
  );
  assign ext_rise = ext_lvl & ~ext_prev;

  gpt_tick_gen #(.PSC_W(GPT_PSC_W), .DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart_psc(wr_mode),
    .src(mode_q.clk_src), .psc(mode_q.psc), .ext_rise(ext_rise), .tick(tick)
  );

  // counter and compare
  assign wrap_now = mode_q.restart && (cnt_q == ref_q);
  assign cnt_inc  = wrap_now ? '0 : cnt_q + 1'b1;
  assign ref_hit  = tick && !wr_cnt && (cnt_inc == ref_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (wr_cnt) cnt_q <= '0;
    else if (tick)   cnt_q <= cnt_inc;
  end

  // capture
  gpt_capture #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .edge_sel(mode_q.cap_edge),
    .cnt(cnt_q), .cap_evt(cap_evt), .cap_val(cap_val)
  );

  // event flags: hardware set beats a software clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_flag <= 1'b0;
      ref_flag <= 1'b0;
    end else begin
      if (cap_evt)                     cap_flag <= 1'b1;
      else if (wr_evt && bus_wdata[0]) cap_flag <= 1'b0;
      if (ref_hit)                     ref_flag <= 1'b1;
      else if (wr_evt && bus_wdata[1]) ref_flag <= 1'b0;
    end
  end

  // output pin
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  tmr_out <= 1'b1;
    else if (ref_hit)            tmr_out <= mode_q.out_toggle ? ~tmr_out : 1'b0;
    else if (!mode_q.out_toggle) tmr_out <= 1'b1;
  end

  assign irq = (cap_flag & mode_q.cap_ie) | (ref_flag & mode_q.ref_ie);

  // R5: a restarting counter that sits on the reference goes back to zero
  a_r5_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_cnt && mode_q.restart && (cnt_q == ref_q)) |=> (cnt_q == '0));
  // R7: a counter write always leaves zero
  a_r7_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> (cnt_q == '0));
  // R8: in pulse mode a low output lasts one cycle unless another match follows
  a_r8_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_out && !mode_q.out_toggle && !ref_hit && !wr_mode) |=> tmr_out);
  // R11: a match sets the flag even when a clear arrives together
  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ref_hit |=> ref_flag);
  // R11: a clear with no competing event empties the capture flag
  a_r11_w1c_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && bus_wdata[0] && !cap_evt) |=> !cap_flag);
  // R9: in toggle mode the pin only moves at a match
  a_r9_toggle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q.out_toggle && !ref_hit) |=> $stable(tmr_out));
endmodule

// File: tb/gpt_timer_tb.sv
module gpt_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic        ext_clk_in = 1'b0, cap_in = 1'b0;
  logic        tmr_out, irq;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  gpt_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_clk_in(ext_clk_in), .cap_in(cap_in), .tmr_out(tmr_out), .irq(irq)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<190000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [15:0] mk(input int psc, input int edg, input int cie,
                                     input int tog, input int rie, input int rst,
                                     input int src);
    return {psc[7:0], edg[1:0], cie[0], tog[0], rie[0], rst[0], src[1:0]};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    bus_addr = a; #1; v = int'(bus_rdata);
  endtask

  task automatic setup(input logic [15:0] m, input logic [15:0] rv, input logic lvl);
    wr(3'd0, 16'h0000);
    cap_in = lvl;
    wr(3'd4, 16'h0003);
    wr(3'd3, rv);
    wr(3'd2, 16'h0000);
    wr(3'd0, m);
  endtask

  initial begin
    int v, init_out, m, mc, rr, p;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 / R2 reset state through the register map
    rd(3'd0, v); chk("R1 mode", v, 0);
    rd(3'd1, v); chk("R1 capture", v, 0);
    rd(3'd2, v); chk("R1 counter", v, 0);
    rd(3'd3, v); chk("R2 reference", v, 16'hFFFF);
    rd(3'd4, v); chk("R1 event", v, 0);
    chk("R1 tmr_out", tmr_out, 1);
    chk("R1 irq", irq, 0);

    // R4 R5 R8: prescale x reference sweep, restart + pulse, source 1
    for (int pi = 0; pi < 4; pi++) begin
      for (int ri = 0; ri < 3; ri++) begin
        rr = (ri == 0) ? 1 : (ri == 1) ? 2 : 4;
        setup(mk(pi, 0, 0, 0, 1, 1, 1), 16'(rr), 1'b0);
        for (int k = 1; k <= 2 * (rr + 1) * (pi + 1) + 1; k++) begin
          bit hit;
          step(1);
          hit = (k % (pi + 1) == 0) && (((k / (pi + 1)) % (rr + 1)) == rr);
          rd(3'd2, v); chk("R5 restart count", v, (k / (pi + 1)) % (rr + 1));
          chk("R8 pulse", tmr_out, hit ? 0 : 1);
        end
        rd(3'd4, v); chk("R8 ref flag", v, 2);
        chk("R12 irq ref", irq, 1);
      end
    end

    // R9 R6: toggle, free run, single match
    setup(mk(0, 0, 0, 1, 0, 0, 1), 16'd3, 1'b0);
    init_out = tmr_out;
    for (int k = 1; k <= 20; k++) begin
      step(1);
      rd(3'd2, v); chk("R6 free count", v, k);
      chk("R9 toggle once", tmr_out, (k >= 3) ? (init_out ^ 1) : init_out);
    end
    rd(3'd4, v); chk("R12 irq gated off", irq, 0);

    // R9: toggle with restart, prescale 1, reference 2
    setup(mk(1, 0, 0, 1, 0, 1, 1), 16'd2, 1'b0);
    init_out = tmr_out; mc = 0;
    for (int k = 1; k <= 24; k++) begin
      step(1);
      if ((k % 2 == 0) && (((k / 2) % 3) == 2)) mc++;
      chk("R9 toggle restart", tmr_out, init_out ^ (mc & 1));
    end

    // R6 wrap and late match, reference 5, pulse, free run
    setup(mk(0, 0, 0, 0, 0, 0, 1), 16'd5, 1'b0);
    step(65535);
    rd(3'd2, v); chk("R6 at top", v, 16'hFFFF);
    step(1);
    rd(3'd2, v); chk("R6 wrapped", v, 0);
    step(4);
    chk("R8 before match", tmr_out, 1);
    step(1);
    chk("R8 match after wrap", tmr_out, 0);
    rd(3'd2, v); chk("R6 after wrap", v, 5);

    // R3 R4: divide by 16 source
    for (int pi = 0; pi < 3; pi += 2) begin
      setup(mk(pi, 0, 0, 0, 0, 0, 2), 16'hFFFF, 1'b0);
      for (int k = 1; k <= 48 * (pi + 1) + 2; k++) begin
        step(1);
        rd(3'd2, v); chk("R3 div16 count", v, k / (16 * (pi + 1)));
      end
    end

    // R3: stopped source
    setup(mk(0, 0, 0, 0, 0, 0, 0), 16'hFFFF, 1'b0);
    step(30);
    rd(3'd2, v); chk("R3 stopped", v, 0);

    // R3 R4: external source, prescale 1
    p = 1;
    setup(mk(p, 0, 0, 0, 0, 0, 3), 16'hFFFF, 1'b0);
    for (int i = 1; i <= 10; i++) begin
      ext_clk_in = 1; step(3);
      ext_clk_in = 0; step(3);
      rd(3'd2, v); chk("R3 ext count", v, i / (p + 1));
    end

    // R10 R12: rising edge only, capture irq enabled
    setup(mk(0, 1, 1, 0, 0, 0, 1), 16'hFFFF, 1'b0);
    step(10);
    cap_in = 1; step(2);
    rd(3'd4, v); chk("R10 not yet", v, 0);
    step(1);
    rd(3'd1, v); chk("R10 rise value", v, 12);
    rd(3'd4, v); chk("R10 cap flag", v, 1);
    chk("R12 irq cap", irq, 1);
    wr(3'd4, 16'h0001);
    chk("R11 w1c irq", irq, 0);
    cap_in = 0; step(4);
    rd(3'd1, v); chk("R10 fall ignored", v, 12);
    rd(3'd4, v); chk("R10 fall no flag", v, 0);

    // R10: falling edge
    setup(mk(0, 2, 0, 0, 0, 0, 1), 16'hFFFF, 1'b1);
    step(7);
    cap_in = 0; step(3);
    rd(3'd1, v); chk("R10 fall value", v, 9);
    chk("R12 cap irq disabled", irq, 0);

    // R10: either edge
    setup(mk(0, 3, 0, 0, 0, 0, 1), 16'hFFFF, 1'b0);
    step(5);
    cap_in = 1; step(3);
    rd(3'd1, v); chk("R10 any rise", v, 7);
    step(4);
    cap_in = 0; step(3);
    rd(3'd1, v); chk("R10 any fall", v, 14);

    // R10: disabled capture
    setup(mk(0, 0, 0, 0, 0, 0, 1), 16'hFFFF, 1'b0);
    rd(3'd1, m);
    cap_in = 1; step(4); cap_in = 0; step(4);
    rd(3'd1, v); chk("R10 off value", v, m);
    rd(3'd4, v); chk("R10 off flag", v, 0);

    // R8 R10 R11: capture and match in one cycle; set beats clear
    setup(mk(0, 1, 1, 0, 1, 1, 1), 16'd10, 1'b0);
    step(7);
    cap_in = 1; step(2);
    rd(3'd4, v); chk("R11 none before", v, 0);
    step(1);
    rd(3'd4, v); chk("R11 both at once", v, 3);
    rd(3'd1, v); chk("R10 same cycle value", v, 9);
    rd(3'd2, v); chk("R5 at ref", v, 10);
    step(10);
    wr(3'd4, 16'h0003);
    rd(3'd4, v); chk("R11 set wins", v, 2);
    rd(3'd2, v); chk("R5 second match", v, 10);
    wr(3'd4, 16'h0002);
    rd(3'd4, v); chk("R11 w1c ref", v, 0);
    cap_in = 0;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule